// File: doc/BRIEF.md
# Pulse-Counting Phase-Flip Demodulator

This block recovers a data stream from a binary phase-shift keyed carrier that arrives as two clamped, complementary square waves. It runs on a fast system clock. A phase reversal in the carrier shows up as a negative half-cycle that lasts twice as long as normal. The block does not lock to the carrier phase. It opens an enable window for each negative half-cycle and runs a gated pulse source only inside that window. It then counts pulses with a small divider that clears whenever the window closes. One pulse means a normal half-cycle. Two pulses mean a phase reversal, and a reversal toggles the recovered data bit.

The path is fully synchronous. The two carrier phases pass through a two-flop synchronizer. A non-overlapping phase generator follows, with a dead gap counted in clock cycles, and its second phase is the enable window. Next come a down-counter pulse source restarted at each window, a two-stage thermometer divider, the exclusive-OR of the divider stages, and a toggle register. The recovered bit follows the sent data after a fixed delay, and that delay is the same for rising and falling data edges.

Top module: `bpsk_flip_demod`

## Requirements
- R1: While reset is low, and on the first sample after it is released with the carrier idle, `rx_bit`, `flip_strobe` and `win_en` are all 0.
- R2: The first enable window after reset never toggles `rx_bit`, even when that window is stretched to twice the normal length.
- R3: `win_en` goes high exactly GAP_CYC+3 clock edges after `car_neg` rises (and `car_pos` falls), counting the first edge that samples the new level as edge 0. It goes low exactly 2 edges after `car_neg` falls.
- R4: The two internal phases are never high together. Before either one rises, both have been low for at least GAP_CYC consecutive cycles.
- R5: The gated pulse source emits its first pulse in the first cycle of an enable window and then one pulse every 2·PULSE_HALF cycles. A normal-length negative half-cycle therefore gives one pulse and does not change `rx_bit`.
- R6: A negative half-cycle stretched to twice its length gives exactly one one-cycle `flip_strobe`. `rx_bit` inverts on the cycle after the strobe and holds its value in every other cycle.
- R7: The divider saturates once it reaches a count of two, so a window that holds three or more pulses still gives exactly one strobe and one toggle. The divider stages form a thermometer code and never read 2'b10.
- R8: A stretched positive half-cycle produces no strobe and leaves `rx_bit` unchanged.
- R9: The pulse divider is cleared in every cycle after `win_en` is low. Normal windows therefore never add up to a detection.
- R10: With bit lengths of 1.5·T0 + n·T0 (n = 0 and n = 2), `rx_bit` sampled at each bit centre plus a fixed latency equals the sent bit. The delay from a rising data edge and from a falling data edge is the same number of cycles.
- R11: `flip_strobe` is high only while `win_en` is high, never lasts two cycles in a row, and fires once for each data transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 64 MHz |
| rst_n | input | 1 | Active-low reset |
| car_pos | input | 1 | Clamped positive carrier phase |
| car_neg | input | 1 | Clamped negative carrier phase, the modulation carrier |
| rx_bit | output | 1 | Recovered data bit |
| flip_strobe | output | 1 | One-cycle pulse when a window counts two pulses |
| win_en | output | 1 | Enable window from the second non-overlapping phase |

## Verification
The bench builds the block with GAP_CYC = 1 and PULSE_HALF = 31 at a 4 ns clock, with a carrier half-period of 62 cycles. A normal window is then 60 cycles long and sees only the pulse at cycle 0. A stretched window sees the second pulse at cycle 62, and a triple window sees a third pulse at cycle 124, which is enough to reach the divider's saturation. The short dead gap makes the exact enable-rise delay of GAP_CYC+3 edges visible at the port. Random data streams with n = 0 and n = 2 are built from runs of odd length, so every phase reversal stretches a negative half-cycle.

// File: rtl/bpsk_flip_demod.sv
module bpsk_flip_demod #(
  parameter int GAP_CYC    = 1,
  parameter int PULSE_HALF = 31
) (
  input  logic clk,
  input  logic rst_n,
  input  logic car_pos,
  input  logic car_neg,
  output logic rx_bit,
  output logic flip_strobe,
  output logic win_en
);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam int PW = $clog2(PULSE_HALF + 1);
  localparam logic [GW-1:0] GAP_V = GW'(GAP_CYC);
  localparam logic [PW-1:0] TMR_LD = PW'(PULSE_HALF - 1);

  logic [1:0]    pos_sy, neg_sy;
  logic          pos_s, neg_s;
  logic          ph1, ph2, ph2_q;
  logic [GW-1:0] gap_cnt;
  logic          gap_open;
  logic [PW-1:0] tmr;
  logic          osc_ph, pulse, pulse_q, pulse_rise;
  logic [1:0]    div;
  logic          det, det_q, armed, rx_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pos_sy <= 2'b00;
      neg_sy <= 2'b00;
    end else begin
      pos_sy <= {pos_sy[0], car_pos};
      neg_sy <= {neg_sy[0], car_neg};
    end

  assign pos_s    = pos_sy[1];
  assign neg_s    = neg_sy[1];
  assign gap_open = !ph1 && !ph2 && (gap_cnt == GAP_V);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph1     <= 1'b0;
      ph2     <= 1'b0;
      gap_cnt <= '0;
    end else begin
      if (ph1 || ph2)           gap_cnt <= '0;
      else if (gap_cnt != GAP_V) gap_cnt <= gap_cnt + 1'b1;
      ph1 <= ph1 ? pos_s : (gap_open && pos_s && !neg_s);
      ph2 <= ph2 ? neg_s : (gap_open && neg_s && !pos_s);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tmr    <= TMR_LD;
      osc_ph <= 1'b1;
    end else if (!ph2) begin
      tmr    <= TMR_LD;
      osc_ph <= 1'b1;
    end else if (tmr == '0) begin
      tmr    <= TMR_LD;
      osc_ph <= ~osc_ph;
    end else begin
      tmr <= tmr - 1'b1;
    end

  assign pulse      = ph2 && osc_ph;
  assign pulse_rise = pulse && !pulse_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   div <= 2'b00;
    else if (!ph2)                div <= 2'b00;
    else if (pulse_rise && !div[1]) div <= {div[0], 1'b1};

  assign det         = div[0] ^ div[1];
  assign flip_strobe = det_q && !det && div[1] && armed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pulse_q <= 1'b0;
      det_q   <= 1'b0;
      ph2_q   <= 1'b0;
      armed   <= 1'b0;
      rx_q    <= 1'b0;
    end else begin
      pulse_q <= pulse;
      det_q   <= det;
      ph2_q   <= ph2;
      armed   <= armed || (ph2_q && !ph2);
      rx_q    <= rx_q ^ flip_strobe;
    end

  assign rx_bit = rx_q;
  assign win_en = ph2;
endmodule

// File: rtl/bpsk_flip_demod_chk.sv
module bpsk_flip_demod_chk #(
  parameter int GAP_CYC = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ph1,
  input logic       ph2,
  input logic [1:0] div,
  input logic       strobe,
  input logic       rx
);
  int unsigned low_run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       low_run <= 0;
    else if (ph1 || ph2)              low_run <= 0;
    else if (low_run < GAP_CYC)       low_run <= low_run + 1;

  AST_NO_OVERLAP:   assert property (@(posedge clk) disable iff (!rst_n) !(ph1 && ph2));                  // R4
  AST_GAP_PH2:      assert property (@(posedge clk) disable iff (!rst_n) $rose(ph2) |-> low_run >= GAP_CYC); // R4
  AST_GAP_PH1:      assert property (@(posedge clk) disable iff (!rst_n) $rose(ph1) |-> low_run >= GAP_CYC); // R4
  AST_DIV_CLEAR:    assert property (@(posedge clk) disable iff (!rst_n) !ph2 |=> div == 2'b00);           // R9
  AST_DIV_THERMO:   assert property (@(posedge clk) disable iff (!rst_n) div != 2'b10);                    // R7
  AST_STROBE_WIN:   assert property (@(posedge clk) disable iff (!rst_n) strobe |-> ph2);                  // R11
  AST_STROBE_ONE:   assert property (@(posedge clk) disable iff (!rst_n) strobe |=> !strobe);              // R11
  AST_RX_TOGGLE:    assert property (@(posedge clk) disable iff (!rst_n) strobe |=> rx != $past(rx));      // R6
  AST_RX_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) !strobe |=> $stable(rx));         // R6
endmodule

bind bpsk_flip_demod bpsk_flip_demod_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ph1(ph1), .ph2(ph2), .div(div),
  .strobe(flip_strobe), .rx(rx_bit)
);

// File: tb/bpsk_flip_demod_bench.sv
module bpsk_flip_demod_bench;
  localparam int GAP = 1;
  localparam int PH  = 31;
  localparam int H   = 62;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic car_pos = 1'b1;
  logic car_neg = 1'b0;
  logic rx_bit, flip_strobe, win_en;

  int errs = 0;
  int checks = 0;
  int stb_cnt = 0;
  int lat = 7;
  int cyc_cnt = 0;
  bit s_rx, s_stb, s_en;

  always #2 clk = ~clk;

  bpsk_flip_demod #(.GAP_CYC(GAP), .PULSE_HALF(PH)) u_bpsk_flip_demod (
    .clk(clk), .rst_n(rst_n), .car_pos(car_pos), .car_neg(car_neg),
    .rx_bit(rx_bit), .flip_strobe(flip_strobe), .win_en(win_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit negv);
    @(negedge clk);
    car_neg = negv;
    car_pos = ~negv;
    @(posedge clk);
    #1;
    s_rx = rx_bit; s_stb = flip_strobe; s_en = win_en;
    if (s_stb) stb_cnt++;
  endtask

  task automatic halves(input bit negv, input int mult);
    repeat (mult * H) cyc(negv);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; car_pos = 1'b1; car_neg = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk(rx_bit == 0 && flip_strobe == 0 && win_en == 0, "R1 reset outputs",
        {rx_bit, flip_strobe, win_en}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    stb_cnt = 0;
    halves(0, 2);
    chk(s_rx == 0 && s_en == 0 && stb_cnt == 0, "R1 idle after reset",
        {s_rx, s_en}, 0);
  endtask

  task automatic run_stream(input int n, input int nb, input bit meas);
    int L, bl, m, mi, k, mr, mf, rr, rf, flips;
    bit val, pm, pr, negv;
    bit bv[64];
    L = 3 + 2 * n; bl = L * H;
    for (int i = 0; i < 3; i++) bv[i] = 1'b0;
    m = 3; val = 1'b1;
    while (m < nb) begin
      int len;
      len = meas ? 1 : 2 * int'($urandom % 2) + 1;
      for (int j = 0; j < len && m < nb; j++) begin bv[m] = val; m++; end
      val = ~val;
    end
    flips = 0;
    for (int i = 1; i < nb; i++) if (bv[i] != bv[i-1]) flips++;
    mr = -1; mf = -1; rr = -1; rf = -1; pm = 0; pr = 0;
    stb_cnt = 0;
    for (int t = 0; t < nb * bl; t++) begin
      mi = t / bl; k = t / H;
      negv = ((k % 2) == 0) ^ bv[mi];
      cyc(negv);
      if (meas) begin
        if (bv[mi] && !pm && mr < 0) mr = t;
        if (!bv[mi] && pm && mf < 0) mf = t;
        if (s_rx && !pr && rr < 0) rr = t;
        if (!s_rx && pr && rf < 0) rf = t;
        pm = bv[mi]; pr = s_rx;
      end else if (t >= lat && ((t - lat) % bl) == bl / 2) begin
        chk(s_rx == bv[(t - lat) / bl], "R10 bit at centre", s_rx, bv[(t - lat) / bl]);
      end
    end
    if (meas) begin
      lat = rr - mr;
      chk(rr >= 0 && lat > 0 && lat < bl / 2, "R10 latency in range", lat, 1);
      chk(rf - mf == rr - mr, "R10 equal rise and fall delay", rf - mf, rr - mr);
    end
    chk(stb_cnt == flips, "R11 one strobe per transition", stb_cnt, flips);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc_cnt, 150000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int ri, fi;
    void'($urandom(32'h5EED1234));
    do_reset();

    // R3 R4: enable window rise and fall timing
    ri = -1;
    for (int i = 0; i < H; i++) begin
      cyc(1);
      if (s_en && ri < 0) ri = i;
    end
    chk(ri == GAP + 3, "R3 R4 enable rise delay", ri, GAP + 3);
    fi = -1;
    for (int i = 0; i < H; i++) begin
      cyc(0);
      if (!s_en && fi < 0) fi = i;
    end
    chk(fi == 2, "R3 enable fall delay", fi, 2);

    // R2: stretched first window after reset is ignored
    do_reset();
    stb_cnt = 0;
    halves(1, 2); halves(0, 1);
    chk(s_rx == 0 && stb_cnt == 0, "R2 first window ignored", s_rx + stb_cnt, 0);

    // R5 R9: normal windows never toggle
    for (int i = 0; i < 6; i++) begin halves(1, 1); halves(0, 1); end
    chk(s_rx == 0 && stb_cnt == 0, "R5 R9 normal windows", s_rx + stb_cnt, 0);

    // R8: stretched positive half ignored
    halves(1, 1); halves(0, 2); halves(1, 1); halves(0, 1);
    chk(s_rx == 0 && stb_cnt == 0, "R8 positive stretch ignored", s_rx + stb_cnt, 0);

    // R6: stretched negative half toggles once
    halves(1, 2);
    chk(stb_cnt == 1, "R6 one strobe", stb_cnt, 1);
    chk(s_rx == 1, "R6 bit toggled", s_rx, 1);
    halves(0, 1);

    // R7: triple window saturates at one toggle
    halves(1, 3); halves(0, 1);
    chk(stb_cnt == 2, "R7 saturation strobe count", stb_cnt, 2);
    chk(s_rx == 0, "R7 single toggle", s_rx, 0);
    halves(1, 1); halves(0, 1);
    chk(s_rx == 0, "R5 hold after normal", s_rx, 0);

    // R10 R11: streams
    do_reset();
    run_stream(0, 12, 1);
    do_reset();
    run_stream(0, 40, 0);
    do_reset();
    run_stream(2, 24, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule